// File: doc/BRIEF.md
# Unicast Station Address Table with Staged Commit

This block keeps a small table of 48-bit unicast station addresses, each with five control bits, one of which marks the entry as valid. A host fills it through a plain register bus. Each entry takes three writes. The host first selects the entry number, then loads the upper 32 address bits into a holding register, and finally writes the lower 16 address bits together with the control bits. Only that final write copies the whole 53-bit entry into the table, in one clock edge. A half-finished update is therefore never visible to the lookup side.

A receive path presents a destination address on the lookup port. The block answers in the same cycle with a hit flag and the lowest matching entry number. While the receive-enable input is low it always answers "no hit". The multicast group bit (address bit 40) can never be stored as 1, so only unicast addresses can ever match. The host must initialise every entry before it raises receive enable.

The lookup is a purely combinational status path, and the register bus is a single-cycle write strobe with an always-ready read mux. Neither interface has a handshake or back-pressure. A write is taken on every clock edge where `bus_wr` is high.

Register offsets on `bus_addr`: 0 = entry select, 1 = upper-address holding register, 2 = low word and commit, 3 = read-only view of the selected entry's stored upper word. The 48-bit address is ordered with byte 5 in bits 47:40 down to byte 0 in bits 7:0. The upper-address register carries byte 2 in bits 31:24, byte 3 in 23:16, byte 4 in 15:8 and byte 5 in 7:0, so address bit 40 sits at register bit 0. The low-word register carries byte 1 in bits 15:8, byte 0 in bits 7:0 and control bits in 20:16, with bit 20 as the valid flag.

Top module: `uat_table`

## Requirements
- R1: After synchronous reset, the select index, the holding register and every table entry (address, control, valid) are 0, so every register offset reads 0 and no lookup hits.
- R2: Offset 0 stores `bus_wdata[2:0]` as the entry index. Reading it returns the index in bits 2:0 and 0 in bits 31:3.
- R3: A write to offset 1 loads the holding register, and reading offset 1 returns the holding register with the byte layout above.
- R4: A write to offset 0 or 1 leaves every stored table entry unchanged.
- R5: A write to offset 2 stores {control = `bus_wdata[20:16]`, upper = holding register, low = `bus_wdata[15:0]`} into the selected entry at that clock edge. Reading offset 2 then returns control in bits 20:16, the low 16 address bits in 15:0 and 0 in 31:21, and offset 3 returns the stored upper word.
- R6: The commit goes to the index selected at the time of the offset-2 write, even if the index changed after the holding register was loaded. The holding register keeps its value after a commit.
- R7: With receive enable high, `match` is 1 when some valid entry's 48-bit address equals `dest_addr`, and `match_idx` is the lowest such entry number.
- R8: With receive enable low, `match` is 0 and `match_idx` is 0, whatever the table holds.
- R9: An entry whose valid flag (control bit 4, register bit 20) is 0 never produces a hit. When nothing hits, `match_idx` is 0.
- R10: Register bit 0 of offset 1 (address bit 40) is forced to 0 on write and reads 0, so a destination with bit 40 set never hits.
- R11: Writes to offset 3 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe, taken at the rising edge |
| bus_addr | input | 2 | Register offset for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| rx_en | input | 1 | Receive enable; gates the lookup |
| dest_addr | input | 48 | Destination address to look up |
| match | output | 1 | A valid entry equals `dest_addr` while enabled |
| match_idx | output | 3 | Lowest matching entry number, 0 when no hit |

## Verification
Several register write sequences are used to tell the staged commit apart from an eager one. A holding-register write followed by a read of the entry view shows whether storage was touched early. An index change between the two halves shows which index the commit uses, and a write to the read-only view shows whether it is ignored. The lookup is driven with addresses held by one entry, by several entries and by an invalidated entry, which separates the lowest-index priority from any-hit logic and from valid gating. A destination with bit 40 set, and the same lookup with receive enable low, show the group-bit forcing and the enable gate.

// File: rtl/uat_pkg.sv
package uat_pkg;
  localparam int BUS_DW    = 32;
  localparam int MAC_W     = 48;
  localparam int LO_W      = 16;
  localparam int HI_W      = MAC_W - LO_W;
  localparam int CTRL_W    = 5;
  localparam int CTRL_LSB  = 16;
  localparam int VALID_BIT = CTRL_W - 1;
  localparam int GROUP_POS = 0;   // address bit 40 inside the upper register

  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_HI   = 2'd1,
    REG_LO   = 2'd2,
    REG_VIEW = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [HI_W-1:0]   hi;
    logic [LO_W-1:0]   lo;
  } entry_t;

  // The upper register lists bytes 2..5 from its top byte downward,
  // so the bytes are reversed when forming the 48-bit address.
  function automatic logic [MAC_W-1:0] to_mac(input logic [HI_W-1:0] hi,
                                              input logic [LO_W-1:0] lo);
    logic [HI_W-1:0] swapped;
    for (int b = 0; b < HI_W/8; b++) begin
      swapped[b*8 +: 8] = hi[HI_W-8-b*8 +: 8];
    end
    return {swapped, lo};
  endfunction
endpackage

// File: rtl/uat_regs.sv
module uat_regs
  import uat_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [HI_W-1:0]     shadow_hi,
  output logic                commit_en,
  output entry_t              commit_data
);
  localparam logic [HI_W-1:0] GROUP_MASK = HI_W'(1) << GROUP_POS;

  logic [IDX_W-1:0] sel_q;
  logic [HI_W-1:0]  shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      shadow_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == REG_SEL) sel_q    <= bus_wdata[IDX_W-1:0];
      if (bus_addr == REG_HI)  shadow_q <= bus_wdata[HI_W-1:0] & ~GROUP_MASK;
    end
  end

  always_comb begin
    commit_en        = bus_wr && (bus_addr == REG_LO);
    commit_data.ctrl = bus_wdata[CTRL_LSB +: CTRL_W];
    commit_data.hi   = shadow_q;
    commit_data.lo   = bus_wdata[LO_W-1:0];
  end

  assign sel_idx   = sel_q;
  assign shadow_hi = shadow_q;
endmodule

// File: rtl/uat_store.sv
module uat_store
  import uat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  entry_t                  wr_data,
  output entry_t [NUM_ENTRIES-1:0] tbl
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    entry_t q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))     q <= wr_data;
    end
    assign tbl[g] = q;
  end
endmodule

// File: rtl/uat_match.sv
module uat_match
  import uat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  entry_t [NUM_ENTRIES-1:0] tbl,
  input  logic [MAC_W-1:0]         dest_addr,
  input  logic                     rx_en,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic             any_hit;
  logic [IDX_W-1:0] first_idx;

  // Scan from the top so the lowest matching entry is written last.
  always_comb begin
    any_hit   = 1'b0;
    first_idx = '0;
    for (int i = NUM_ENTRIES-1; i >= 0; i--) begin
      if (tbl[i].ctrl[VALID_BIT] && (to_mac(tbl[i].hi, tbl[i].lo) == dest_addr)) begin
        any_hit   = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end

  assign hit     = rx_en && any_hit;
  assign hit_idx = hit ? first_idx : '0;
endmodule

// File: rtl/uat_table.sv
module uat_table
  import uat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_en,
  input  logic [47:0] dest_addr,
  output logic        match,
  output logic [2:0]  match_idx
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [IDX_W-1:0]          sel_idx;
  logic [HI_W-1:0]           shadow_hi;
  logic                      commit_en;
  entry_t                    commit_data;
  entry_t [NUM_ENTRIES-1:0]  tbl;
  entry_t                    cur;

  uat_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sel_idx(sel_idx), .shadow_hi(shadow_hi),
    .commit_en(commit_en), .commit_data(commit_data)
  );

  uat_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(commit_en), .wr_idx(sel_idx),
    .wr_data(commit_data), .tbl(tbl)
  );

  uat_match #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_match (
    .tbl(tbl), .dest_addr(dest_addr), .rx_en(rx_en),
    .hit(match), .hit_idx(match_idx)
  );

  assign cur = tbl[sel_idx];

  always_comb begin
    unique case (bus_addr)
      REG_SEL:  bus_rdata = BUS_DW'(sel_idx);
      REG_HI:   bus_rdata = BUS_DW'(shadow_hi);
      REG_LO:   bus_rdata = BUS_DW'({cur.ctrl, cur.lo});
      default:  bus_rdata = BUS_DW'(cur.hi);
    endcase
  end
endmodule

// File: rtl/uat_table_chk.sv
module uat_table_chk
  import uat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr,
  input logic [1:0]               bus_addr,
  input logic [31:0]              bus_wdata,
  input logic [31:0]              bus_rdata,
  input logic                     rx_en,
  input logic [47:0]              dest_addr,
  input logic                     match,
  input logic [2:0]               match_idx,
  input logic [IDX_W-1:0]         sel_idx,
  input logic [HI_W-1:0]          shadow_hi,
  input entry_t [NUM_ENTRIES-1:0] tbl
);
  // R8: lookup is silent while reception is disabled
  a_r8_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> (!match && match_idx == '0));

  // R7 and R9: a reported hit names a valid entry holding the destination
  a_r7_hit_is_real: assert property (@(posedge clk) disable iff (rst)
    match |-> (tbl[match_idx].ctrl[VALID_BIT] &&
               to_mac(tbl[match_idx].hi, tbl[match_idx].lo) == dest_addr));

  // R4 and R11: only the low-word offset may change stored entries
  a_r4_only_low_commits: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != REG_LO) |=> $stable(tbl));

  // R5 and R6: the commit lands at the index selected on the low-word write
  a_r5_commit_lands: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_LO) |=>
      tbl[$past(sel_idx)] == entry_t'({$past(bus_wdata[CTRL_LSB +: CTRL_W]),
                                       $past(shadow_hi),
                                       $past(bus_wdata[LO_W-1:0])}));

  // R10: the group bit never appears in the holding register
  a_r10_group_bit_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_HI) |-> !bus_rdata[GROUP_POS]);

  // R2: reserved bits of the select register read as zero
  a_r2_sel_reserved: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_SEL) |-> (bus_rdata[31:IDX_W] == '0));
endmodule

bind uat_table uat_table_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_en(rx_en),
  .dest_addr(dest_addr), .match(match), .match_idx(match_idx),
  .sel_idx(sel_idx), .shadow_hi(shadow_hi), .tbl(tbl)
);

// File: tb/uat_table_test.sv
module uat_table_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_en;
  logic [47:0] dest_addr;
  logic        match;
  logic [2:0]  match_idx;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  uat_table uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_en(rx_en),
    .dest_addr(dest_addr), .match(match), .match_idx(match_idx)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'h0,         32'h0},          // R1 select after reset
    '{1'b0, 2'd1, 32'h0,         32'h0},          // R1 holding after reset
    '{1'b0, 2'd2, 32'h0,         32'h0},          // R1 entry 0 low
    '{1'b0, 2'd3, 32'h0,         32'h0},          // R1 entry 0 upper
    '{1'b1, 2'd0, 32'hFFFF_FFFD, 32'h0},          // select entry 5
    '{1'b0, 2'd0, 32'h0,         32'h0000_0005},  // R2 reserved bits zero
    '{1'b1, 2'd1, 32'h1122_3345, 32'h0},          // load holding, bit 0 set
    '{1'b0, 2'd1, 32'h0,         32'h1122_3344},  // R3 R10 bit 0 cleared
    '{1'b0, 2'd3, 32'h0,         32'h0},          // R4 entry 5 untouched
    '{1'b1, 2'd2, 32'hFFF1_AABB, 32'h0},          // commit entry 5
    '{1'b0, 2'd2, 32'h0,         32'h0011_AABB},  // R5 low word and control
    '{1'b0, 2'd3, 32'h0,         32'h1122_3344},  // R5 upper word stored
    '{1'b1, 2'd1, 32'hDEAD_BEEF, 32'h0},          // load holding
    '{1'b1, 2'd0, 32'h0000_0002, 32'h0},          // change index afterwards
    '{1'b1, 2'd2, 32'h0010_0102, 32'h0},          // commit
    '{1'b0, 2'd2, 32'h0,         32'h0010_0102},  // R6 landed at entry 2
    '{1'b0, 2'd3, 32'h0,         32'hDEAD_BEEE},  // R6 upper at entry 2
    '{1'b1, 2'd0, 32'h0000_0005, 32'h0},          // back to entry 5
    '{1'b0, 2'd3, 32'h0,         32'h1122_3344},  // R6 entry 5 unchanged
    '{1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0},          // write read-only view
    '{1'b0, 2'd3, 32'h0,         32'h1122_3344},  // R11 view write ignored
    '{1'b0, 2'd1, 32'h0,         32'hDEAD_BEEE}   // R6 holding kept after commit
  };

  function automatic logic [47:0] mac_of(input logic [31:0] hi, input logic [15:0] lo);
    return {hi[7:0], hi[15:8], hi[23:16], hi[31:24], lo};
  endfunction

  task automatic check(input logic [47:0] got, input logic [47:0] exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] off, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = off;
    #2;
    check(48'(bus_rdata), 48'(exp), req);
  endtask

  task automatic lookup(input logic en, input logic [47:0] d, input logic exp_hit,
                        input logic [2:0] exp_idx, input string req);
    @(negedge clk);
    rx_en = en; dest_addr = d;
    #2;
    check(48'({match, match_idx}), 48'({exp_hit, exp_idx}), req);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    rx_en = 1'b0; dest_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].off, VEC[i].data);
      else           bus_read(VEC[i].off, VEC[i].exp, $sformatf("vector %0d", i));
    end

    lookup(1'b1, mac_of(32'h1122_3344, 16'hAABB), 1'b1, 3'd5, "R7 single hit entry 5");
    lookup(1'b1, mac_of(32'hDEAD_BEEE, 16'h0102), 1'b1, 3'd2, "R7 single hit entry 2");
    lookup(1'b0, mac_of(32'h1122_3344, 16'hAABB), 1'b0, 3'd0, "R8 disabled");

    bus_write(2'd0, 32'd6);
    bus_write(2'd1, 32'h1122_3344);
    bus_write(2'd2, 32'h0010_AABB);
    lookup(1'b1, mac_of(32'h1122_3344, 16'hAABB), 1'b1, 3'd5, "R7 lowest of 5 and 6");
    bus_write(2'd0, 32'd1);
    bus_write(2'd2, 32'h0010_AABB);
    lookup(1'b1, mac_of(32'h1122_3344, 16'hAABB), 1'b1, 3'd1, "R7 lowest of 1, 5, 6");
    bus_write(2'd2, 32'h0000_AABB);
    lookup(1'b1, mac_of(32'h1122_3344, 16'hAABB), 1'b1, 3'd5, "R9 invalid entry 1 skipped");
    lookup(1'b1, 48'h0, 1'b0, 3'd0, "R9 zero entries not valid");

    bus_write(2'd0, 32'd3);
    bus_write(2'd1, 32'h5566_7701);
    bus_write(2'd2, 32'h0010_3344);
    bus_read(2'd3, 32'h5566_7700, "R10 stored group bit");
    lookup(1'b1, mac_of(32'h5566_7701, 16'h3344), 1'b0, 3'd0, "R10 group dest no hit");
    lookup(1'b1, mac_of(32'h5566_7700, 16'h3344), 1'b1, 3'd3, "R10 unicast dest hits");

    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    bus_read(2'd0, 32'h0, "R1 select after reset");
    bus_read(2'd1, 32'h0, "R1 holding after reset");
    bus_read(2'd2, 32'h0, "R1 entry low after reset");
    lookup(1'b1, mac_of(32'h1122_3344, 16'hAABB), 1'b0, 3'd0, "R1 no hit after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule